// File: doc/BRIEF.md
# Exception entry controller

This block decides, once per clock, whether the processor core must enter an exception and, if so, which one. It looks at seven pending sources (release from reset, an undefined instruction, a software interrupt request, a prefetch abort, a data abort, a normal interrupt and a fast interrupt), qualifies each against the current status word and the pipeline state, and picks a single winner by fixed priority.

For the winner it computes everything the core needs to write in one cycle: the handler address, the new status word with its mode field and mask bits, the copy of the old status word to be banked, and the return link value. All results are registered; a one-cycle `take_exc` strobe marks the cycle in which the core should commit them, together with a kind code. Pipeline control, the banked register storage, any coprocessor handshake and the handler software are outside the block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are all zero and `take_exc` is 0.
- R2: When several qualified sources are pending, the winner is, from highest to lowest: reset release, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. `exc_kind` codes are 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 6 normal interrupt, 7 fast interrupt.
- R3: The new status bits [4:0] carry the mode code of the winner: 5'b10011 for reset and software interrupt, 5'b11011 for undefined, 5'b10111 for both aborts, 5'b10010 for normal interrupt, 5'b10001 for fast interrupt.
- R4: The handler address is a base plus four times the kind code; the base is 32'hFFFF0000 when `hi_vec` is 1 and zero otherwise.
- R5: On every entry, status bit 5 is cleared, bit 7 is set, bit 9 takes `endian_exc`, and bits [31:10] are copied from `cur_status`.
- R6: Status bit 6 is set on reset and fast interrupt entry and copied from `cur_status` otherwise; bit 8 is set on every entry except undefined and software interrupt, where it is copied.
- R7: The link value is `next_addr` for undefined and software interrupt, `exec_addr`+4 for prefetch abort, `exec_addr`+8 for data abort, and `next_addr`+4 for both interrupts.
- R8: The saved status equals `cur_status` for every kind except reset, where saved status and link are both driven to zero.
- R9: A normal interrupt qualifies only when `insn_boundary` is 1 and `cur_status` bit 7 is 0; a fast interrupt only when `insn_boundary` is 1 and bit 6 is 0.
- R10: With `vec_irq_en` at 1, both interrupt kinds take `vec_addr` as handler address; other kinds keep their fixed vector.
- R11: Undefined, software interrupt and prefetch abort requests qualify only when `exec_valid` is 1; a flushed prefetch abort causes no entry.
- R12: Outputs follow the inputs sampled at the previous rising edge; `take_exc` is 1 only in a cycle after a qualifying request, and in other cycles the data outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_req | input | 1 | Reset release pending |
| undef_req | input | 1 | Executing instruction is undefined |
| swi_req | input | 1 | Executing instruction requests a software interrupt |
| pabt_req | input | 1 | Executing instruction was fetched with an abort |
| dabt_req | input | 1 | Data access abort |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| exec_valid | input | 1 | Instruction in execute is real (not flushed) |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| cur_status | input | 32 | Current status word |
| exec_addr | input | 32 | Address of the executing instruction |
| next_addr | input | 32 | Address of the next instruction |
| hi_vec | input | 1 | Select the high vector base |
| vec_irq_en | input | 1 | Interrupts use the external vector |
| vec_addr | input | 32 | External interrupt handler address |
| endian_exc | input | 1 | Endianness value loaded on entry |
| take_exc | output | 1 | One-cycle commit strobe |
| exc_kind | output | 3 | Kind code of the entry |
| new_pc | output | 32 | Handler address |
| new_status | output | 32 | Status word after entry |
| saved_status | output | 32 | Status word to bank |
| link_val | output | 32 | Return link value |

## Verification
A wrong priority or qualification shows up at the ports in the very next cycle as a wrong `exc_kind` or a missing or extra `take_exc`, and a wrong mask or mode bit shows in `new_status` on that same strobe. Because every output is a register loaded only on a strobe, a corrupted hold path appears as a data output that drifts in a cycle with `take_exc` low, one cycle after the fault. The bench model therefore compares every output on every clock, through masked, flushed and simultaneous request patterns, so any divergence is caught one cycle after the edge that caused it.

// File: rtl/exc_entry_pkg.sv
// Shared kind codes, mode codes and status bit positions for the
// exception entry controller. Assumes a status word of at least 10 bits.
package exc_entry_pkg;

    // Kind code equals the vector offset divided by four.
    typedef enum logic [2:0] {
        EK_BOOT  = 3'd0,
        EK_UNDEF = 3'd1,
        EK_SVC   = 3'd2,
        EK_PABT  = 3'd3,
        EK_DABT  = 3'd4,
        EK_IRQ   = 3'd6,
        EK_FIQ   = 3'd7
    } exc_kind_e;

    localparam int NSRC = 7;          // number of request sources

    localparam int ST_TSTATE = 5;     // instruction-set state bit
    localparam int ST_FMASK  = 6;     // fast interrupt mask
    localparam int ST_IMASK  = 7;     // normal interrupt mask
    localparam int ST_AMASK  = 8;     // imprecise abort mask
    localparam int ST_ENDIAN = 9;     // data endianness
    localparam int ST_MIN_W  = 10;

    // Mode code written into status bits [4:0] for a kind.
    function automatic logic [4:0] mode_of(exc_kind_e k);
        case (k)
            EK_UNDEF:         return 5'b11011;
            EK_PABT, EK_DABT: return 5'b10111;
            EK_IRQ:           return 5'b10010;
            EK_FIQ:           return 5'b10001;
            default:          return 5'b10011;
        endcase
    endfunction

    // Kind for a priority rank (rank 0 is highest).
    function automatic exc_kind_e rank_kind(int r);
        case (r)
            1:       return EK_DABT;
            2:       return EK_FIQ;
            3:       return EK_IRQ;
            4:       return EK_PABT;
            5:       return EK_UNDEF;
            6:       return EK_SVC;
            default: return EK_BOOT;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
// Fixed-priority picker. Bit 0 of req is the highest priority.
// Produces a one-hot (or zero) win vector and an any-request flag.
module exc_prio_arb #(
    parameter int N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         any
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_rank
            if (i == 0) begin : g_top
                // Highest rank wins whenever it requests.
                assign win[i] = req[i];
            end else begin : g_low
                // Lower rank wins only if nothing above requests.
                assign win[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    // Any qualified request at all.
    assign any = |req;

endmodule

// File: rtl/exc_status_gen.sv
// Builds the post-entry status word from the current one for a kind.
// Assumes SW >= 10 so all control bit positions exist.
module exc_status_gen
    import exc_entry_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic [SW-1:0] cur_status,
    input  exc_kind_e     kind,
    input  logic          endian_exc,
    output logic [SW-1:0] nxt_status
);

    // Mode, masks and endianness update; remaining bits pass through.
    always_comb begin
        nxt_status            = cur_status;
        nxt_status[4:0]       = mode_of(kind);
        nxt_status[ST_TSTATE] = 1'b0;
        nxt_status[ST_IMASK]  = 1'b1;
        nxt_status[ST_ENDIAN] = endian_exc;
        if (kind == EK_BOOT || kind == EK_FIQ)
            nxt_status[ST_FMASK] = 1'b1;
        if (kind != EK_UNDEF && kind != EK_SVC)
            nxt_status[ST_AMASK] = 1'b1;
    end

endmodule

// File: rtl/exc_target_gen.sv
// Computes handler address and return link value for a kind.
// Fixed vectors sit at base + 4*kind; interrupts may be vectored externally.
module exc_target_gen
    import exc_entry_pkg::*;
#(
    parameter int          AW      = 32,
    parameter logic [AW-1:0] HI_BASE = 32'hFFFF0000
) (
    input  exc_kind_e     kind,
    input  logic          hi_vec,
    input  logic          vec_irq_en,
    input  logic [AW-1:0] vec_addr,
    input  logic [AW-1:0] exec_addr,
    input  logic [AW-1:0] next_addr,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] link
);

    localparam logic [AW-1:0] WORD  = AW'(4);
    localparam logic [AW-1:0] DWORD = AW'(8);

    logic [AW-1:0] fixed_vec;
    logic          is_intr;

    // Fixed vector from base and kind offset.
    always_comb begin
        fixed_vec = (hi_vec ? HI_BASE : '0) | AW'({kind, 2'b00});
        is_intr   = (kind == EK_IRQ) || (kind == EK_FIQ);
        pc        = (vec_irq_en && is_intr) ? vec_addr : fixed_vec;
    end

    // Return link selection per kind.
    always_comb begin
        case (kind)
            EK_UNDEF, EK_SVC: link = next_addr;
            EK_PABT:          link = exec_addr + WORD;
            EK_DABT:          link = exec_addr + DWORD;
            EK_IRQ, EK_FIQ:   link = next_addr + WORD;
            default:          link = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller top. Qualifies the seven request sources,
// picks one by priority and registers the full entry update for the core.
// Assumes requests are level inputs sampled once per clock.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int            AW      = 32,
    parameter int            SW      = 32,
    parameter logic [AW-1:0] HI_BASE = 32'hFFFF0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_req,
    input  logic          undef_req,
    input  logic          swi_req,
    input  logic          pabt_req,
    input  logic          dabt_req,
    input  logic          irq_req,
    input  logic          fiq_req,
    input  logic          exec_valid,
    input  logic          insn_boundary,
    input  logic [SW-1:0] cur_status,
    input  logic [AW-1:0] exec_addr,
    input  logic [AW-1:0] next_addr,
    input  logic          hi_vec,
    input  logic          vec_irq_en,
    input  logic [AW-1:0] vec_addr,
    input  logic          endian_exc,
    output logic          take_exc,
    output logic [2:0]    exc_kind,
    output logic [AW-1:0] new_pc,
    output logic [SW-1:0] new_status,
    output logic [SW-1:0] saved_status,
    output logic [AW-1:0] link_val
);

    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] win;
    logic            any;
    exc_kind_e       kind;
    logic [SW-1:0]   nxt_status;
    logic [AW-1:0]   nxt_pc;
    logic [AW-1:0]   nxt_link;

    // Qualify each source, placed at its priority rank.
    always_comb begin
        req_q[0] = boot_req;
        req_q[1] = dabt_req;
        req_q[2] = fiq_req & insn_boundary & ~cur_status[ST_FMASK];
        req_q[3] = irq_req & insn_boundary & ~cur_status[ST_IMASK];
        req_q[4] = pabt_req & exec_valid;
        req_q[5] = undef_req & exec_valid;
        req_q[6] = swi_req & exec_valid;
    end

    exc_prio_arb #(.N(NSRC)) u_arb (
        .req (req_q),
        .win (win),
        .any (any)
    );

    // Map the winning rank to its kind code.
    always_comb begin
        kind = EK_BOOT;
        for (int r = 0; r < NSRC; r++)
            if (win[r]) kind = rank_kind(r);
    end

    exc_status_gen #(.SW(SW)) u_status (
        .cur_status (cur_status),
        .kind       (kind),
        .endian_exc (endian_exc),
        .nxt_status (nxt_status)
    );

    exc_target_gen #(.AW(AW), .HI_BASE(HI_BASE)) u_target (
        .kind       (kind),
        .hi_vec     (hi_vec),
        .vec_irq_en (vec_irq_en),
        .vec_addr   (vec_addr),
        .exec_addr  (exec_addr),
        .next_addr  (next_addr),
        .pc         (nxt_pc),
        .link       (nxt_link)
    );

    // Register the entry update; hold data outputs when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_exc     <= 1'b0;
            exc_kind     <= 3'd0;
            new_pc       <= '0;
            new_status   <= '0;
            saved_status <= '0;
            link_val     <= '0;
        end else begin
            take_exc <= any;
            if (any) begin
                exc_kind     <= kind;
                new_pc       <= nxt_pc;
                new_status   <= nxt_status;
                saved_status <= (kind == EK_BOOT) ? '0 : cur_status;
                link_val     <= nxt_link;
            end
        end
    end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Property checker for the exception entry controller, bound to the top.
// Relates registered outputs to inputs sampled one edge earlier.
module exc_entry_ctrl_chk
    import exc_entry_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boot_req,
    input logic          dabt_req,
    input logic          fiq_req,
    input logic          irq_req,
    input logic          exec_valid,
    input logic          insn_boundary,
    input logic [SW-1:0] cur_status,
    input logic          vec_irq_en,
    input logic [AW-1:0] vec_addr,
    input logic          endian_exc,
    input logic          take_exc,
    input logic [2:0]    exc_kind,
    input logic [AW-1:0] new_pc,
    input logic [SW-1:0] new_status,
    input logic [SW-1:0] saved_status
);

    assert_boot_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(boot_req)) |-> (take_exc && exc_kind == EK_BOOT));

    assert_mode_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (new_status[4:0] == mode_of(exc_kind_e'(exc_kind))));

    assert_entry_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (!new_status[ST_TSTATE] && new_status[ST_IMASK]
                      && new_status[ST_ENDIAN] == $past(endian_exc)));

    assert_fmask_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_kind != EK_BOOT && exc_kind != EK_FIQ)
        |-> (new_status[ST_FMASK] == $past(cur_status[ST_FMASK])));

    assert_saved_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_kind != EK_BOOT) |-> (saved_status == $past(cur_status)));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_kind == EK_IRQ)
        |-> (!$past(cur_status[ST_IMASK]) && $past(insn_boundary) && $past(irq_req)));

    assert_fiq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_kind == EK_FIQ)
        |-> (!$past(cur_status[ST_FMASK]) && $past(insn_boundary) && $past(fiq_req)));

    assert_vectored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && (exc_kind == EK_IRQ || exc_kind == EK_FIQ) && $past(vec_irq_en))
        |-> (new_pc == $past(vec_addr)));

    assert_exec_qual_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && (exc_kind == EK_UNDEF || exc_kind == EK_SVC || exc_kind == EK_PABT))
        |-> $past(exec_valid));

    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(boot_req | dabt_req | fiq_req | irq_req | exec_valid))
        |-> !take_exc);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !take_exc) |-> ($stable(new_pc) && $stable(new_status)));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.AW(AW), .SW(SW)) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed
// cases with literal expected values, then a random phase.
module exc_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_req = 0, undef_req = 0, swi_req = 0, pabt_req = 0, dabt_req = 0;
    logic        irq_req = 0, fiq_req = 0, exec_valid = 0, insn_boundary = 0;
    logic [31:0] cur_status = 0, exec_addr = 0, next_addr = 0, vec_addr = 0;
    logic        hi_vec = 0, vec_irq_en = 0, endian_exc = 0;
    logic        take_exc;
    logic [2:0]  exc_kind;
    logic [31:0] new_pc, new_status, saved_status, link_val;

    int total = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    exc_entry_ctrl uut (.*);

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Reference model state.
    logic        m_take = 0;
    logic [2:0]  m_kind = 0;
    logic [31:0] m_pc = 0, m_st = 0, m_sv = 0, m_lk = 0;

    // Model update at each edge, then compare one step later.
    always @(posedge clk) begin
        int k;
        if (!rst_n) begin
            m_take = 0; m_kind = 0; m_pc = 0; m_st = 0; m_sv = 0; m_lk = 0;
        end else begin
            k = -1;
            if (boot_req) k = 0;
            else if (dabt_req) k = 4;
            else if (fiq_req && insn_boundary && !cur_status[6]) k = 7;
            else if (irq_req && insn_boundary && !cur_status[7]) k = 6;
            else if (exec_valid && pabt_req) k = 3;
            else if (exec_valid && undef_req) k = 1;
            else if (exec_valid && swi_req) k = 2;
            m_take = (k >= 0);
            if (k >= 0) begin
                m_kind = 3'(k);
                m_st = cur_status;
                case (k)
                    1: m_st[4:0] = 5'h1B;
                    3, 4: m_st[4:0] = 5'h17;
                    6: m_st[4:0] = 5'h12;
                    7: m_st[4:0] = 5'h11;
                    default: m_st[4:0] = 5'h13;
                endcase
                m_st[5] = 0; m_st[7] = 1; m_st[9] = endian_exc;
                if (k == 0 || k == 7) m_st[6] = 1;
                if (k != 1 && k != 2) m_st[8] = 1;
                if (vec_irq_en && k >= 6) m_pc = vec_addr;
                else m_pc = (hi_vec ? 32'hFFFF0000 : 32'h0) + 32'(k * 4);
                m_sv = (k == 0) ? 32'h0 : cur_status;
                case (k)
                    1, 2: m_lk = next_addr;
                    3: m_lk = exec_addr + 4;
                    4: m_lk = exec_addr + 8;
                    6, 7: m_lk = next_addr + 4;
                    default: m_lk = 0;
                endcase
            end
        end
        #1;
        chk("R2", {cur_req, " take"}, {31'b0, take_exc}, {31'b0, m_take});
        chk("R2", {cur_req, " kind"}, {29'b0, exc_kind}, {29'b0, m_kind});
        chk("R4", {cur_req, " pc"}, new_pc, m_pc);
        chk("R5", {cur_req, " status"}, new_status, m_st);
        chk("R8", {cur_req, " saved"}, saved_status, m_sv);
        chk("R7", {cur_req, " link"}, link_val, m_lk);
    end

    task automatic clear_reqs();
        boot_req = 0; undef_req = 0; swi_req = 0; pabt_req = 0; dabt_req = 0;
        irq_req = 0; fiq_req = 0; exec_valid = 0; insn_boundary = 0;
    endtask

    // Wait until the outputs reflect the inputs driven at the last negedge.
    task automatic settle();
        @(posedge clk); #1.5;
    endtask

    task automatic next_drive();
        @(negedge clk); clear_reqs();
    endtask

    // Watchdog: a hung run still reaches the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        chk("R1", "take in reset", {31'b0, take_exc}, 32'h0);
        chk("R1", "pc in reset", new_pc, 32'h0);
        rst_n = 1;

        // Reset entry: masks set, flags kept, saved and link zero.
        @(negedge clk); cur_req = "R6";
        cur_status = 32'hF0000010; endian_exc = 1; boot_req = 1;
        settle();
        chk("R6", "boot status", new_status, 32'hF00003D3);
        chk("R8", "boot link", link_val, 32'h0);
        chk("R4", "boot pc", new_pc, 32'h0);
        next_drive();

        // Undefined: low vector, link = next.
        cur_req = "R7"; cur_status = 32'h10; endian_exc = 0;
        exec_valid = 1; undef_req = 1; next_addr = 32'h1004; exec_addr = 32'h1000;
        settle();
        chk("R3", "undef status", new_status, 32'h0000009B);
        chk("R7", "undef link", link_val, 32'h1004);
        chk("R4", "undef pc", new_pc, 32'h4);
        chk("R8", "undef saved", saved_status, 32'h10);
        next_drive();

        // Software interrupt with high vectors.
        cur_req = "R4"; hi_vec = 1; exec_valid = 1; swi_req = 1;
        settle();
        chk("R4", "swi pc", new_pc, 32'hFFFF0008);
        chk("R3", "swi status", new_status, 32'h00000093);
        next_drive();
        hi_vec = 0;

        // Flushed prefetch abort: nothing taken, outputs held.
        cur_req = "R11"; pabt_req = 1; exec_valid = 0;
        settle();
        chk("R11", "flushed pabt take", {31'b0, take_exc}, 32'h0);
        chk("R12", "held pc", new_pc, 32'hFFFF0008);
        next_drive();

        // Prefetch abort that executes.
        cur_req = "R11"; pabt_req = 1; exec_valid = 1; exec_addr = 32'h2000;
        settle();
        chk("R7", "pabt link", link_val, 32'h2004);
        chk("R6", "pabt status", new_status, 32'h00000197);
        next_drive();

        // Data abort.
        cur_req = "R7"; dabt_req = 1;
        settle();
        chk("R7", "dabt link", link_val, 32'h2008);
        chk("R4", "dabt pc", new_pc, 32'h10);
        next_drive();

        // Interrupt masked, then off-boundary, then taken.
        cur_req = "R9"; cur_status = 32'h90; irq_req = 1; insn_boundary = 1;
        settle();
        chk("R9", "masked irq", {31'b0, take_exc}, 32'h0);
        next_drive();
        cur_status = 32'h10; irq_req = 1; insn_boundary = 0;
        settle();
        chk("R9", "irq off boundary", {31'b0, take_exc}, 32'h0);
        next_drive();
        irq_req = 1; insn_boundary = 1; next_addr = 32'h3000;
        settle();
        chk("R9", "irq pc", new_pc, 32'h18);
        chk("R7", "irq link", link_val, 32'h3004);
        next_drive();

        // Fast beats normal interrupt.
        cur_req = "R2"; irq_req = 1; fiq_req = 1; insn_boundary = 1;
        settle();
        chk("R2", "fiq over irq kind", {29'b0, exc_kind}, 32'h7);
        chk("R6", "fiq status", new_status, 32'h000001D1);
        next_drive();

        // Data abort beats fast interrupt; reset beats all.
        dabt_req = 1; fiq_req = 1; insn_boundary = 1;
        settle();
        chk("R2", "dabt over fiq", {29'b0, exc_kind}, 32'h4);
        next_drive();
        boot_req = 1; dabt_req = 1; fiq_req = 1; insn_boundary = 1;
        settle();
        chk("R2", "boot over all", {29'b0, exc_kind}, 32'h0);
        next_drive();
        exec_valid = 1; undef_req = 1; swi_req = 1;
        settle();
        chk("R2", "undef over swi", {29'b0, exc_kind}, 32'h1);
        next_drive();

        // Vectored interrupts; undefined keeps fixed vector.
        cur_req = "R10"; vec_irq_en = 1; vec_addr = 32'h80000040;
        irq_req = 1; insn_boundary = 1;
        settle();
        chk("R10", "vectored irq pc", new_pc, 32'h80000040);
        next_drive();
        exec_valid = 1; undef_req = 1;
        settle();
        chk("R10", "undef ignores vector", new_pc, 32'h4);
        next_drive();
        vec_irq_en = 0;

        // Idle cycle holds outputs.
        cur_req = "R12";
        settle();
        chk("R12", "idle take", {31'b0, take_exc}, 32'h0);
        chk("R12", "idle hold pc", new_pc, 32'h4);

        // Random phase, model compares every clock.
        cur_req = "R5";
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            boot_req = ($urandom_range(0, 15) == 0);
            undef_req = ($urandom_range(0, 7) == 0);
            swi_req = ($urandom_range(0, 7) == 0);
            pabt_req = ($urandom_range(0, 7) == 0);
            dabt_req = ($urandom_range(0, 11) == 0);
            irq_req = ($urandom_range(0, 3) == 0);
            fiq_req = ($urandom_range(0, 5) == 0);
            exec_valid = $urandom_range(0, 1) == 1;
            insn_boundary = $urandom_range(0, 1) == 1;
            cur_status = $urandom;
            exec_addr = $urandom;
            next_addr = $urandom;
            vec_addr = $urandom;
            hi_vec = $urandom_range(0, 1) == 1;
            vec_irq_en = $urandom_range(0, 1) == 1;
            endian_exc = $urandom_range(0, 1) == 1;
        end
        @(negedge clk); clear_reqs();

        // Reset mid-run clears outputs.
        cur_req = "R1"; rst_n = 0;
        settle();
        chk("R1", "reset clears status", new_status, 32'h0);
        @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule